// File: doc/BRIEF.md
# Feed-locked watchdog timer

This block is a memory-mapped watchdog for a single clock domain. A fixed divider produces one tick every four clocks, and on each tick a 24-bit down-counter steps toward zero. When the counter wraps past zero while the watchdog is running, the block raises a one-clock reset request and sets a sticky timeout flag. The counter then reloads from the timeout register and keeps counting.

Software keeps the system alive by writing a two-step key to the feed register. The first write carries 0xAA in its low byte and the second carries 0x55. A complete key reloads the counter from the timeout register. Setting the enable bit does not start the countdown: the counter runs only after the first complete key that arrives while enable is set. After that, enable cannot be cleared. If the key starts and is then broken, either by a wrong second byte or by any other bus access in between, a running watchdog requests reset at once.

Register reads are combinational from the address. A bus access is one cycle with `bus_valid` high. Word offsets: 0x0 is control/status, 0x4 is the timeout reload value, 0x8 is the feed key, and 0xC is the live count.

Top module: `feedlock_wdt`

## Requirements
- R1: While running, the count falls by exactly one every 4 clocks. If a complete key is written on clock edge F and the reload value is T, the count reads T after edge F+3 and T-k after edge F+4k.
- R2: After reset, control/status reads 0, the reload value reads 0xFF, the live count reads 0xFF and `wdt_reset_o` is low.
- R3: Control/status (0x0) has enable in bit 0, reset-enable in bit 1 and the timeout flag in bit 2. The feed register (0x8) reads 0. The live count (0xC) is read-only, and writes to it are ignored.
- R4: A write to the reload value (0x4) keeps the low 24 bits and raises any value below 0xFF to 0xFF. A new reload value does not change the live count until the next complete key.
- R5: A complete key reloads the live count from the reload value. The key is a feed write whose low byte is 0xAA, followed directly by a feed write whose low byte is 0x55.
- R6: Setting enable alone leaves the count frozen. A complete key given while enable is clear reloads the count but does not start it. The count runs only after a complete key given with enable set.
- R7: Once set, enable stays set until reset. Writing 0 to bit 0 has no effect, while bit 1 stays writable.
- R8: A broken key asserts `wdt_reset_o` for one clock, on the cycle after the offending write, when the watchdog is running and reset-enable is set. A broken key is a feed write after 0xAA whose low byte is not 0x55. When the watchdog is not running, a broken key produces no reset.
- R9: Any other bus access between the 0xAA write and its follower aborts the key and counts as a broken key. This includes a read access or a write to another register.
- R10: When a tick finds the count at 0 while running, `wdt_reset_o` pulses high for one clock if reset-enable is set, the timeout flag sets (even with reset-enable clear), and the count reloads and keeps running.
- R11: The timeout flag is cleared by writing 0 to bit 2. Writing 1 leaves it unchanged.
- R12: A feed write whose low byte is not 0xAA, made while no key is pending, is ignored and never causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | One bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdt_reset_o | output | 1 | One-clock reset request |

## Verification
The assertions assume that each bus access lasts one clock with `bus_valid` high, and that the address and data are known whenever `bus_valid` is high. They also assume no access is made while `rst_n` is low. The bench changes bus signals only on falling edges, releases `bus_valid` after every access, and reads registers by driving the address with `bus_valid` low, so that a read does not break a pending key. Reads with `bus_valid` high are used only in the test that deliberately aborts a key.

// File: rtl/fwdt_pkg.sv
package fwdt_pkg;
    localparam int OFF_CTRL  = 'h0;
    localparam int OFF_RELD  = 'h4;
    localparam int OFF_FEED  = 'h8;
    localparam int OFF_COUNT = 'hC;

    localparam int BIT_ENABLE = 0;
    localparam int BIT_RSTEN  = 1;
    localparam int BIT_FLAG   = 2;
endpackage

// File: rtl/fwdt_feed_seq.sv
module fwdt_feed_seq #(
    parameter int          KEY_W     = 8,
    parameter logic [7:0]  KEY_OPEN  = 8'hAA,
    parameter logic [7:0]  KEY_CLOSE = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             feed_wr_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             good_o,
    output logic             bad_o
);
    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        good_o = 1'b0;
        bad_o  = 1'b0;
        if (acc_i) begin
            if (feed_wr_i) begin
                if (!st_q.armed) begin
                    if (key_i == KEY_W'(KEY_OPEN)) st_d.armed = 1'b1;
                end else begin
                    st_d.armed = 1'b0;
                    if (key_i == KEY_W'(KEY_CLOSE)) good_o = 1'b1;
                    else                             bad_o  = 1'b1;
                end
            end else if (st_q.armed) begin
                st_d.armed = 1'b0;
                bad_o      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_KEY_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        good_o |=> !good_o); // R5
    AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o |=> !bad_o); // R9
endmodule

// File: rtl/fwdt_prescaler.sv
module fwdt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] ph;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (clr_i) begin
            st_d.ph = '0;
        end else if (run_i) begin
            if (st_q.ph == PW'(DIV - 1)) begin
                st_d.ph = '0;
                tick_o  = 1'b1;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
endmodule

// File: rtl/fwdt_countdown.sv
module fwdt_countdown #(
    parameter int          CNT_W   = 24,
    parameter int unsigned RST_VAL = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cd_t;

    cd_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                wrap_o   = 1'b1;
                st_d.cnt = load_val_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CNT_W'(RST_VAL)};
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == $past(load_val_i))); // R10
endmodule

// File: rtl/feedlock_wdt.sv
module feedlock_wdt #(
    parameter int          CNT_W     = 24,
    parameter int          DIV       = 4,
    parameter int unsigned TMO_MIN   = 255,
    parameter int          KEY_W     = 8,
    parameter logic [7:0]  KEY_OPEN  = 8'hAA,
    parameter logic [7:0]  KEY_CLOSE = 8'h55,
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_reset_o
);
    import fwdt_pkg::*;

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(TMO_MIN);

    typedef struct packed {
        logic             en;
        logic             rst_en;
        logic             flag;
        logic             running;
        logic             rst_out;
        logic [CNT_W-1:0] tmo;
    } wdt_t;

    wdt_t st_d, st_q;

    logic             hit_ctrl, hit_reld, hit_feed, hit_count;
    logic             feed_good, feed_bad;
    logic             tick, wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wr_val;
    logic             unused_wbits;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_reld  = (bus_addr == ADDR_W'(OFF_RELD));
    assign hit_feed  = (bus_addr == ADDR_W'(OFF_FEED));
    assign hit_count = (bus_addr == ADDR_W'(OFF_COUNT));
    assign wr_val    = bus_wdata[CNT_W-1:0];
    assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];

    fwdt_feed_seq #(
        .KEY_W     (KEY_W),
        .KEY_OPEN  (KEY_OPEN),
        .KEY_CLOSE (KEY_CLOSE)
    ) u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (bus_valid),
        .feed_wr_i (bus_we && hit_feed),
        .key_i     (bus_wdata[KEY_W-1:0]),
        .good_o    (feed_good),
        .bad_o     (feed_bad)
    );

    fwdt_prescaler #(
        .DIV (DIV)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.running),
        .clr_i  (feed_good),
        .tick_o (tick)
    );

    fwdt_countdown #(
        .CNT_W   (CNT_W),
        .RST_VAL (TMO_MIN)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (feed_good),
        .load_val_i (st_q.tmo),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    always_comb begin
        st_d = st_q;
        if (bus_valid && bus_we) begin
            if (hit_ctrl) begin
                st_d.en     = st_q.en | bus_wdata[BIT_ENABLE];
                st_d.rst_en = bus_wdata[BIT_RSTEN];
                if (!bus_wdata[BIT_FLAG]) st_d.flag = 1'b0;
            end
            if (hit_reld) begin
                st_d.tmo = (wr_val < FLOOR) ? FLOOR : wr_val;
            end
        end
        if (feed_good && st_q.en) st_d.running = 1'b1;
        if (wrap)                 st_d.flag    = 1'b1;
        st_d.rst_out = st_q.running && st_q.rst_en && (wrap || feed_bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tmo <= FLOOR;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[BIT_ENABLE] = st_q.en;
            bus_rdata[BIT_RSTEN]  = st_q.rst_en;
            bus_rdata[BIT_FLAG]   = st_q.flag;
        end else if (hit_reld) begin
            bus_rdata[CNT_W-1:0] = st_q.tmo;
        end else if (hit_count) begin
            bus_rdata[CNT_W-1:0] = cnt;
        end
    end

    assign wdt_reset_o = st_q.rst_out;

    AST_ENABLE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> st_q.en); // R7
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && !feed_good) |=> $stable(cnt)); // R6
    AST_RESET_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |=> !wdt_reset_o); // R10
    AST_NO_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.running |=> !wdt_reset_o); // R8
    AST_FEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        feed_good |=> (cnt == $past(st_q.tmo))); // R5
    AST_BROKEN_KEY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_bad && st_q.running && st_q.rst_en) |=> wdt_reset_o); // R9
endmodule

// File: tb/feedlock_wdt_bench.sv
`timescale 1ns/1ps
module feedlock_wdt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    feedlock_wdt u_feedlock_wdt (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_reset_o (wdt_reset_o)
    );

    localparam logic [3:0] A_CTRL = 4'h0, A_RELD = 4'h4, A_FEED = 4'h8, A_CNT = 4'hC;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, A_CTRL, 32'h0,        32'h0,        4'd2},  // R2 control clear
        '{1'b0, A_RELD, 32'h0,        32'h0000FF,   4'd2},  // R2 reload default
        '{1'b0, A_CNT,  32'h0,        32'h0000FF,   4'd2},  // R2 count default
        '{1'b0, A_FEED, 32'h0,        32'h0,        4'd3},  // R3 feed reads 0
        '{1'b1, A_RELD, 32'h10,       32'h0,        4'd4},
        '{1'b0, A_RELD, 32'h0,        32'h0000FF,   4'd4},  // R4 clamp
        '{1'b1, A_RELD, 32'h12345678, 32'h0,        4'd4},
        '{1'b0, A_RELD, 32'h0,        32'h345678,   4'd4},  // R4 24 bits kept
        '{1'b0, A_CNT,  32'h0,        32'h0000FF,   4'd4},  // R4 count untouched
        '{1'b1, A_CNT,  32'h55,       32'h0,        4'd3},
        '{1'b0, A_CNT,  32'h0,        32'h0000FF,   4'd3},  // R3 count read-only
        '{1'b1, A_CTRL, 32'h2,        32'h0,        4'd3},
        '{1'b0, A_CTRL, 32'h0,        32'h2,        4'd3},  // R3 bit 1
        '{1'b1, A_CTRL, 32'h0,        32'h0,        4'd3},
        '{1'b0, A_CTRL, 32'h0,        32'h0,        4'd3}   // R3 bit 1 clears
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_access(input logic [3:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic feed();
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h55);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int highs;
        wait_cyc(3);
        check("R2 reset output", {31'b0, wdt_reset_o}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                peek(VECS[i].addr, v);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R6 / R5: key with enable clear reloads but does not run
        do_reset();
        wr(A_RELD, 32'h100);
        feed();
        peek(A_CNT, v); check("R5 reload", v, 32'h100);
        wait_cyc(20);
        peek(A_CNT, v); check("R6 frozen without enable", v, 32'h100);
        wr(A_CTRL, 32'h3);
        wait_cyc(20);
        peek(A_CNT, v); check("R6 enable alone frozen", v, 32'h100);

        // R1: run after key with enable
        feed();
        peek(A_CNT, v); check("R1 start value", v, 32'h100);
        wait_cyc(3);
        peek(A_CNT, v); check("R1 before first tick", v, 32'h100);
        wait_cyc(1);
        peek(A_CNT, v); check("R1 first tick", v, 32'hFF);
        wait_cyc(4);
        peek(A_CNT, v); check("R1 second tick", v, 32'hFE);

        // R7: enable sticky, bit 1 still writable
        wr(A_CTRL, 32'h0);
        peek(A_CTRL, v); check("R7 enable kept", v, 32'h1);
        wr(A_CTRL, 32'h2);
        peek(A_CTRL, v); check("R7 reset-enable set", v, 32'h3);

        // R12: stray feed byte ignored
        wr(A_FEED, 32'h12);
        check("R12 no reset", {31'b0, wdt_reset_o}, 32'h0);
        wr(A_FEED, 32'h55);
        check("R12 lone close ignored", {31'b0, wdt_reset_o}, 32'h0);

        // R8: broken key
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'hAA);
        check("R8 broken key reset", {31'b0, wdt_reset_o}, 32'h1);
        wait_cyc(1);
        check("R8 pulse ends", {31'b0, wdt_reset_o}, 32'h0);
        peek(A_CTRL, v); check("R8 flag untouched", v, 32'h3);

        // R9: aborts by other accesses
        wr(A_FEED, 32'hAA);
        wr(A_RELD, 32'h0);
        check("R9 write abort", {31'b0, wdt_reset_o}, 32'h1);
        wr(A_FEED, 32'hAA);
        rd_access(A_CTRL);
        check("R9 read abort", {31'b0, wdt_reset_o}, 32'h1);

        // R10: wrap with reset-enable (reload is 0xFF after clamped write)
        feed();
        wait_cyc(1023);
        check("R10 before wrap", {31'b0, wdt_reset_o}, 32'h0);
        peek(A_CNT, v); check("R10 count at zero", v, 32'h0);
        wait_cyc(1);
        check("R10 wrap reset", {31'b0, wdt_reset_o}, 32'h1);
        peek(A_CNT, v); check("R10 reloaded", v, 32'hFF);
        peek(A_CTRL, v); check("R10 flag set", v, 32'h7);
        wait_cyc(1);
        check("R10 single clock", {31'b0, wdt_reset_o}, 32'h0);
        wait_cyc(4);
        peek(A_CNT, v); check("R10 keeps running", v, 32'hFE);

        // R11: flag clear semantics
        wr(A_CTRL, 32'h6);
        peek(A_CTRL, v); check("R11 write 1 keeps flag", v, 32'h7);
        wr(A_CTRL, 32'h3);
        peek(A_CTRL, v); check("R11 write 0 clears flag", v, 32'h3);

        // R10: wrap without reset-enable sets flag only
        wr(A_CTRL, 32'h1);
        feed();
        highs = 0;
        for (int k = 0; k < 1030; k++) begin
            @(negedge clk);
            if (wdt_reset_o) highs++;
        end
        check("R10 no reset when disabled", highs, 0);
        peek(A_CTRL, v); check("R10 flag without reset-enable", v, 32'h5);

        // R8: broken key while not running
        do_reset();
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h00);
        check("R8 idle broken key", {31'b0, wdt_reset_o}, 32'h0);
        wr(A_CTRL, 32'h3);
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'hAA);
        check("R8 enabled not started", {31'b0, wdt_reset_o}, 32'h0);

        finish_run();
    end
endmodule